// File: doc/BRIEF.md
# Single-Wire Bus Identity Enumerator

This block is a bus-master controller that discovers the 64-bit identity code of every slave attached to a single-wire, wired-AND bus. It runs one search pass after another. Each pass opens with a bus reset and a presence check, then sends an 8-bit search command, then resolves the 64 code positions one at a time, least significant position first. For each position the block reads the slaves' bit, reads the complement of that bit, and writes back a direction bit. Slaves whose code disagrees with that direction drop out for the rest of the pass.

When both values are present at a position, the block picks a branch. It does this by comparing the position with a marker it keeps from the previous pass, so the identity tree is walked depth-first and each pass ends on a new leaf. Every finished pass presents one code on `code_o` with a one-cycle strobe. When a pass ends with no unexplored zero branch, the block raises `done_o`. An absent slave population, or a read pair showing no responder, raises `nodev_o` instead. A mode input picks the normal search command or the alarm-only search command.

Bit timing belongs to a separate time-slot engine. This block drives that engine over a request/acknowledge interface.

Top module: `idtree_scan`

## Requirements
- R1: Every pass begins with a reset request. A presence result of 1 lets the pass go on. The pass then writes the command byte least significant bit first: F0h when `alarm_mode_i` was low at start, ECh when it was high.
- R2: `req_o` stays high, with `op_o` and `wbit_o` unchanged, until `ack_i` is sampled high. `op_o` encodings: 0 = reset, 1 = write bit, 2 = read bit. On an acknowledged reset, `rbit_i` carries the presence result. On an acknowledged read, `rbit_i` carries the bit read.
- R3: For each code position 0..63 the block issues a read, a read, then a write. A pair of (bit, complement) = (0,1) writes 0 and a pair of (1,0) writes 1. A full pass therefore makes 72 writes and 128 reads.
- R4: On a (0,0) pair the block applies these rules. At a position below the previous pass's marker it repeats the previous code's bit. At the marker position it writes 1. At any later position it writes 0. Any 0 written on a (0,0) pair becomes the new marker candidate, the highest such position winning.
- R5: A (1,1) pair aborts the pass. `nodev_o` goes high, no code is strobed for that pass, and no further requests are made.
- R6: Each completed pass pulses `code_valid_o` for exactly one cycle, with `code_o` bit i equal to the bit written at position i. Across an enumeration every participating slave is reported once, in ascending order of the code read with bit 0 as the most significant digit.
- R7: `done_o` rises in the same cycle as the final `code_valid_o` pulse, which comes from the first pass that records no zero-branch marker. It stays high until the next accepted start.
- R8: A reset acknowledged with presence 0 raises `nodev_o` with no command bits sent and no code. `done_o` and `nodev_o` are never high together.
- R9: `start_i` is accepted only when the block is idle, done or in error. While a pass is running, a start pulse has no effect on the command, the passes or the codes.
- R10: After reset `req_o`, `code_valid_o`, `done_o` and `nodev_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fresh enumeration; clears the marker |
| alarm_mode_i | input | 1 | Sampled at start: 1 selects the alarm-only search command |
| req_o | output | 1 | Slot request to the time-slot engine |
| op_o | output | 2 | Slot kind: 0 reset, 1 write, 2 read |
| wbit_o | output | 1 | Bit to write for a write slot |
| ack_i | input | 1 | Slot completed |
| rbit_i | input | 1 | Read bit, or presence result for a reset slot |
| code_o | output | 64 | Last discovered identity code |
| code_valid_o | output | 1 | One-cycle strobe for a new code |
| done_o | output | 1 | Enumeration finished, all branches visited |
| nodev_o | output | 1 | Enumeration aborted: no presence or no responder |

## Verification
A corrupt marker or a corrupt stored previous code shows first in the write bits of the next pass. A wrong branch at a (0,0) position sends the pass to a leaf that has already been found, or lets it skip one. At the ports this appears within one pass (about 200 slots) as a repeated code, a code out of order, a missing slave, or `done_o` rising at the wrong pass. A decode slip on a single pair drops every slave from the bus model, and the next read pair shows (1,1) and raises `nodev_o` within three slots.

// File: rtl/idtree_pkg.sv
package idtree_pkg;
  typedef enum logic [1:0] {
    OP_RST = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2
  } slot_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_CMD, S_RD_ID, S_RD_CMP, S_WR_DIR, S_EMIT, S_FIN, S_ERR
  } scan_st_e;
endpackage

// File: rtl/idtree_dir_pick.sv
module idtree_dir_pick #(
  parameter int POS_W = 7
) (
  input  logic             id_i,
  input  logic             cmp_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] mark_i,
  input  logic             prev_i,
  output logic             dir_o,
  output logic             void_o,
  output logic             zero_branch_o
);
  logic split;
  assign split  = ~id_i & ~cmp_i;
  assign void_o = id_i & cmp_i;

  always_comb begin
    if (split) begin
      if (pos_i < mark_i) dir_o = prev_i;
      else                dir_o = (pos_i == mark_i);
    end else begin
      dir_o = id_i;
    end
  end

  assign zero_branch_o = split & ~dir_o;
endmodule

// File: rtl/idtree_code_store.sv
module idtree_code_store #(
  parameter int W     = 64,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  input  logic             commit_i,
  output logic             cur_bit_o,
  output logic             prev_bit_o,
  output logic [W-1:0]     code_o
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      if (set_i)    cur_q[idx_i] <= bit_i;
      if (commit_i) prev_q       <= cur_q;
    end
  end

  assign cur_bit_o  = cur_q[idx_i];
  assign prev_bit_o = prev_q[idx_i];
  assign code_o     = prev_q;
endmodule

// File: rtl/idtree_scan.sv
module idtree_scan
  import idtree_pkg::*;
#(
  parameter int         CODE_W     = 64,
  parameter int         CMD_W      = 8,
  parameter logic [7:0] SEARCH_CMD = 8'hF0,
  parameter logic [7:0] ALARM_CMD  = 8'hEC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              alarm_mode_i,
  output logic              req_o,
  output logic [1:0]        op_o,
  output logic              wbit_o,
  input  logic              ack_i,
  input  logic              rbit_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              done_o,
  output logic              nodev_o
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam int POS_W = $clog2(CODE_W + 1);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W - 1);

  scan_st_e         state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [POS_W-1:0] mark_q, zero_q, pos;
  logic             alarm_q, id_q, valid_q, done_q, nodev_q;
  logic             dir, void_pair, zero_branch, cur_bit, prev_bit;
  logic             active, fire, set_bit;
  logic [CMD_W-1:0] cmd_byte;
  slot_op_e         op;

  assign pos      = POS_W'(idx_q) + POS_W'(1);
  assign cmd_byte = alarm_q ? ALARM_CMD[CMD_W-1:0] : SEARCH_CMD[CMD_W-1:0];
  assign active   = !(state_q inside {S_IDLE, S_FIN, S_ERR});
  assign req_o    = state_q inside {S_RST, S_CMD, S_RD_ID, S_RD_CMP, S_WR_DIR};
  assign fire     = req_o & ack_i;
  assign set_bit  = (state_q == S_RD_CMP) & ack_i & ~void_pair;

  idtree_dir_pick #(.POS_W(POS_W)) u_pick (
    .id_i(id_q), .cmp_i(rbit_i), .pos_i(pos), .mark_i(mark_q), .prev_i(prev_bit),
    .dir_o(dir), .void_o(void_pair), .zero_branch_o(zero_branch)
  );

  idtree_code_store #(.W(CODE_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni, .set_i(set_bit), .idx_i(idx_q), .bit_i(dir),
    .commit_i(state_q == S_EMIT), .cur_bit_o(cur_bit), .prev_bit_o(prev_bit),
    .code_o(code_o)
  );

  always_comb begin
    op     = OP_RD;
    wbit_o = 1'b0;
    case (state_q)
      S_RST:    op = OP_RST;
      S_CMD:    begin op = OP_WR; wbit_o = cmd_byte[cnt_q]; end
      S_WR_DIR: begin op = OP_WR; wbit_o = cur_bit; end
      default:  op = OP_RD;
    endcase
  end
  assign op_o = op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      mark_q  <= '0;
      zero_q  <= '0;
      alarm_q <= 1'b0;
      id_q    <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      nodev_q <= 1'b0;
    end else begin
      valid_q <= (state_q == S_EMIT);
      if (start_i && !active) begin
        state_q <= S_RST;
        mark_q  <= '0;
        alarm_q <= alarm_mode_i;
        done_q  <= 1'b0;
        nodev_q <= 1'b0;
      end else begin
        case (state_q)
          S_RST: if (fire) begin
            if (rbit_i) begin
              state_q <= S_CMD;
              cnt_q   <= '0;
              zero_q  <= '0;
            end else begin
              state_q <= S_ERR;
              nodev_q <= 1'b1;
            end
          end
          S_CMD: if (fire) begin
            if (cnt_q == CMD_LAST) begin
              state_q <= S_RD_ID;
              idx_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_RD_ID: if (fire) begin
            id_q    <= rbit_i;
            state_q <= S_RD_CMP;
          end
          S_RD_CMP: if (fire) begin
            if (void_pair) begin
              state_q <= S_ERR;
              nodev_q <= 1'b1;
            end else begin
              state_q <= S_WR_DIR;
              if (zero_branch) zero_q <= pos;
            end
          end
          S_WR_DIR: if (fire) begin
            if (idx_q == IDX_LAST) state_q <= S_EMIT;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_RD_ID;
            end
          end
          S_EMIT: begin
            mark_q <= zero_q;
            if (zero_q == '0) begin
              state_q <= S_FIN;
              done_q  <= 1'b1;
            end else state_q <= S_RST;
          end
          default: ;
        endcase
      end
    end
  end

  assign code_valid_o = valid_q;
  assign done_o       = done_q;
  assign nodev_o      = nodev_q;

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(op_o) && $stable(wbit_o)));

  assert_void_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_CMP && ack_i && id_q && rbit_i) |=> (nodev_o && !req_o));

  assert_single_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> !code_valid_o);

  assert_done_with_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> code_valid_o);

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && nodev_o));
endmodule

// File: tb/sim_idtree_scan.sv
module sim_idtree_scan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        alarm_mode_i = 1'b0;
  logic        req_o, wbit_o, ack_i, rbit_i;
  logic [1:0]  op_o;
  logic [63:0] code_o;
  logic        code_valid_o, done_o, nodev_o;

  always #10 clk_i = ~clk_i;

  idtree_scan u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [63:0] dev_code [8];
  bit          dev_alarm [8];
  bit          dev_act [8];
  int          ndev = 0;
  bit          present_en = 1;
  int          bit_cnt, pos, phase, n_rd, n_wr, n_rst;
  logic [7:0]  rx_cmd, last_cmd;
  logic [63:0] found [16];
  int          nfound;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic serve();
    bit r;
    case (op_o)
      2'd0: begin
        n_rst++; bit_cnt = 0; pos = 0; phase = 0;
        for (int d = 0; d < 8; d++) dev_act[d] = (d < ndev);
        rbit_i = present_en && (ndev > 0);
      end
      2'd1: begin
        n_wr++;
        if (bit_cnt < 8) begin
          rx_cmd[bit_cnt] = wbit_o;
          bit_cnt++;
          if (bit_cnt == 8) begin
            last_cmd = rx_cmd;
            for (int d = 0; d < 8; d++)
              dev_act[d] &= (rx_cmd == 8'hF0) || (rx_cmd == 8'hEC && dev_alarm[d]);
          end
        end else begin
          for (int d = 0; d < 8; d++)
            if (dev_code[d][pos] != wbit_o) dev_act[d] = 0;
          pos++; phase = 0;
        end
      end
      default: begin
        n_rd++;
        r = 1;
        for (int d = 0; d < 8; d++)
          if (dev_act[d] && pos < 64) r &= (phase == 0) ? dev_code[d][pos] : ~dev_code[d][pos];
        rbit_i = r;
        phase++;
      end
    endcase
  endtask

  initial begin
    ack_i = 0; rbit_i = 0;
    forever begin
      @(negedge clk_i);
      if (ack_i) ack_i = 0;
      else if (req_o) begin
        @(negedge clk_i);
        serve();
        ack_i = 1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk_i);
      if (code_valid_o && nfound < 16) begin
        found[nfound] = code_o;
        nfound++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic kick(input bit alarm);
    nfound = 0; n_rd = 0; n_wr = 0; n_rst = 0; last_cmd = 8'h00;
    @(negedge clk_i);
    alarm_mode_i = alarm; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 30000 && !(done_o || nodev_o); i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // R6 order/uniqueness check against the participant set
  task automatic check_set(input string tag, input bit alarm);
    int expn = 0;
    logic [63:0] ka, kb;
    for (int d = 0; d < ndev; d++) if (!alarm || dev_alarm[d]) expn++;
    chk(nfound == expn, "R6", {tag, " code count"}, 64'(nfound), 64'(expn));
    for (int i = 0; i < nfound; i++) begin
      bit hit = 0;
      for (int d = 0; d < ndev; d++)
        if (found[i] == dev_code[d] && (!alarm || dev_alarm[d])) hit = 1;
      chk(hit, "R6", {tag, " code is a participant"}, found[i], 64'h0);
      if (i > 0) begin
        ka = {<<{found[i-1]}};
        kb = {<<{found[i]}};
        chk(ka < kb, "R4", {tag, " depth-first order"}, found[i], found[i-1]);
      end
    end
    chk(done_o && !nodev_o, "R7", {tag, " done flag"}, {62'd0, done_o, nodev_o}, 64'd2);
    chk(n_wr == 72 * n_rst && n_rd == 128 * n_rst, "R3", {tag, " slots per pass"},
        64'(n_wr), 64'(72 * n_rst));
    chk(n_rst == expn, "R1", {tag, " one reset per pass"}, 64'(n_rst), 64'(expn));
  endtask

  task automatic t_reset();
    chk(!req_o && !code_valid_o && !done_o && !nodev_o, "R10", "reset outputs",
        {60'd0, req_o, code_valid_o, done_o, nodev_o}, 64'd0);
  endtask

  task automatic t_single();
    ndev = 1; dev_code[0] = 64'hA5C3_1122_3344_5510; present_en = 1;
    kick(0); wait_end();
    check_set("single", 0);
    chk(found[0] == 64'hA5C3_1122_3344_5510, "R6", "single code value", found[0], dev_code[0]);
    chk(last_cmd == 8'hF0, "R1", "search command", 64'(last_cmd), 64'hF0);
  endtask

  task automatic t_four();
    ndev = 4;
    dev_code[0] = 64'h0000_0000_0000_0010;
    dev_code[1] = 64'h0000_0000_0000_0011;
    dev_code[2] = 64'h8000_0000_0000_0014;
    dev_code[3] = 64'h0000_0000_0000_0014;
    dev_alarm[0] = 0; dev_alarm[1] = 1; dev_alarm[2] = 0; dev_alarm[3] = 1;
    kick(0); wait_end();
    check_set("four", 0);
    // R4: expected order by reversed value: ..10, ..14, 8..14, ..11
    chk(found[1] == dev_code[3] && found[2] == dev_code[2], "R4", "deep branch order",
        found[2], dev_code[2]);
  endtask

  task automatic t_alarm();
    kick(1); wait_end();
    check_set("alarm", 1);
    chk(last_cmd == 8'hEC, "R1", "alarm command", 64'(last_cmd), 64'hEC);
  endtask

  task automatic t_void();
    for (int d = 0; d < 4; d++) dev_alarm[d] = 0;
    kick(1); wait_end();
    chk(nodev_o && !done_o, "R5", "void pair abort", {62'd0, nodev_o, done_o}, 64'd2);
    chk(nfound == 0, "R5", "no code on abort", 64'(nfound), 64'd0);
    chk(n_rd == 2 && !req_o, "R5", "requests stop", 64'(n_rd), 64'd2);
  endtask

  task automatic t_nopres();
    present_en = 0;
    kick(0); wait_end();
    chk(nodev_o && !done_o, "R8", "absent presence", {62'd0, nodev_o, done_o}, 64'd2);
    chk(n_wr == 0 && nfound == 0, "R8", "no command sent", 64'(n_wr), 64'd0);
    present_en = 1;
  endtask

  task automatic t_busy_start();
    dev_alarm[0] = 1;
    kick(0);
    repeat (300) @(negedge clk_i);
    alarm_mode_i = 1; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    wait_end();
    chk(last_cmd == 8'hF0, "R9", "start ignored while busy", 64'(last_cmd), 64'hF0);
    chk(nfound == 4 && n_rst == 4, "R9", "passes unchanged", 64'(nfound), 64'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_four();
    t_alarm();
    t_void();
    t_nopres();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule